// File: doc/BRIEF.md
# Saturating Capacity-Inaccuracy Charge Counter

This block tracks how many accepted charge events a battery gauge has seen since its learned full-capacity value was last refreshed. Each time the charge-qualification logic signals a valid charge, the block may add one to an 8-bit count. The count tells the host how stale the learned capacity has become. A separate inaccuracy flag rises once the count has climbed far enough that the learned value should no longer be trusted.

Repeated top-up charging of a nearly full battery must not inflate the count. The block therefore compares the present available capacity with 94 % of the learned capacity, using exact integer arithmetic. At or above that level, only one charge is counted, and later charges are ignored until the capacity drops below the level again. A learning update, raised by the capacity-learning logic outside this block, returns everything to its starting state. The count is meant to be exposed read-only as register 09h by a host interface outside this block.

Top module: `cap_inacc_counter`

## Requirements
- R1: After synchronous reset, `charge_cnt` is 0 and `inacc_flag` is 0.
- R2: A `charge_ok` pulse while the capacity is below the threshold (avail×100 < learned×94) raises `charge_cnt` by exactly one, visible after the clock edge that samples the pulse.
- R3: While the capacity is at or above the threshold, the first `charge_ok` pulse is counted.
- R4: After that near-full increment, further `charge_ok` pulses leave `charge_cnt` unchanged while the capacity stays at or above the threshold. Once the capacity has been seen below the threshold, a later near-full pulse is counted again.
- R5: The threshold comparison is exact over the full 16-bit range with no overflow. With learned 100, avail 94 counts as near-full and avail 93 as below. With learned 65535, avail 61603 counts as near-full and 61602 as below.
- R6: `charge_cnt` saturates at 255. Further counted charges leave it at 255 and never wrap to 0.
- R7: `inacc_flag` is 1 exactly when `charge_cnt` is 64 or more. It rises in the same cycle the count becomes 64, and it is 0 at 63.
- R8: A `learn_upd` pulse sets `charge_cnt` to 0, clears `inacc_flag` and re-arms the near-full latch, so the next near-full charge is counted.
- R9: When `learn_upd` and `charge_ok` arrive in the same cycle, the update wins and `charge_cnt` ends at 0.
- R10: With no strobe asserted, `charge_cnt` and `inacc_flag` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| charge_ok | input | 1 | One-cycle strobe marking a qualified charge |
| learn_upd | input | 1 | One-cycle strobe marking a learned-capacity update |
| avail_cap | input | 16 | Present nominal available capacity |
| learned_cap | input | 16 | Learned maximum capacity |
| charge_cnt | output | 8 | Registered saturating charge count |
| inacc_flag | output | 1 | Registered capacity-inaccurate flag |

## Verification
The counting path is tried in several ways. Strings of charges well below the threshold confirm one step per pulse. Runs of charges with the capacity held near full separate a correct single-shot latch from one that counts every pulse or none. A dip below the threshold followed by a return to near-full shows that the latch re-arms. Capacity pairs sitting one unit either side of the 94 % line, at small values and at the top of the 16-bit range, expose a rounded or overflowing comparison. Long runs up to 63, 64 and past 255 locate the flag edge and the saturation point. Update strobes, alone and together with a charge, separate update priority from ordinary counting.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int CIC_CAP_W     = 16;
  localparam int CIC_CNT_W     = 8;
  localparam int CIC_FLAG_LVL  = 64;
  localparam int CIC_PCT_NUM   = 94;
  localparam int CIC_PCT_DEN   = 100;
  localparam logic [7:0] CIC_REG_ADDR = 8'h09;

  // Action chosen for the counter in a given cycle
  typedef enum logic [1:0] {
    EV_HOLD  = 2'd0,
    EV_COUNT = 2'd1,
    EV_CLEAR = 2'd2
  } cic_evt_e;

endpackage

// File: rtl/cic_threshold.sv
module cic_threshold #(
  parameter int CAP_W   = cic_pkg::CIC_CAP_W,
  parameter int PCT_NUM = cic_pkg::CIC_PCT_NUM,
  parameter int PCT_DEN = cic_pkg::CIC_PCT_DEN
) (
  input  logic [CAP_W-1:0] avail_cap,
  input  logic [CAP_W-1:0] learned_cap,
  output logic             near_full
);

  // Product width holds CAP_W bits times the larger ratio term
  localparam int K_W    = $clog2(PCT_DEN + 1);
  localparam int PROD_W = CAP_W + K_W;

  logic [PROD_W-1:0] lhs;
  logic [PROD_W-1:0] rhs;

  always_comb begin
    lhs = PROD_W'(avail_cap)   * PROD_W'(PCT_DEN);
    rhs = PROD_W'(learned_cap) * PROD_W'(PCT_NUM);
    near_full = (lhs >= rhs);
  end

  initial begin
    assert_ratio_ok_R5: assert (PCT_NUM <= PCT_DEN && PCT_DEN > 0)
      else $error("threshold ratio out of range");
  end

endmodule

// File: rtl/cic_gate.sv
module cic_gate (
  input  logic              clk,
  input  logic              rst,
  input  logic              charge_ok,
  input  logic              learn_upd,
  input  logic              near_full,
  output cic_pkg::cic_evt_e evt,
  output logic              inhibit
);
  import cic_pkg::*;

  logic inhibit_nxt;

  always_comb begin
    evt = EV_HOLD;
    if (learn_upd)
      evt = EV_CLEAR;
    else if (charge_ok && (!near_full || !inhibit))
      evt = EV_COUNT;
  end

  always_comb begin
    inhibit_nxt = inhibit;
    if (learn_upd || !near_full)
      inhibit_nxt = 1'b0;
    else if (charge_ok)
      inhibit_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) inhibit <= 1'b0;
    else     inhibit <= inhibit_nxt;
  end

  // Update re-arms the near-full latch (R8)
  assert_learn_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    learn_upd |=> !inhibit);

  // A near-full charge always leaves the latch armed against the next one (R4)
  assert_latch_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (charge_ok && near_full && !learn_upd) |=> inhibit);

endmodule

// File: rtl/cic_counter.sv
module cic_counter #(
  parameter int CNT_W    = cic_pkg::CIC_CNT_W,
  parameter int FLAG_LVL = cic_pkg::CIC_FLAG_LVL
) (
  input  logic              clk,
  input  logic              rst,
  input  cic_pkg::cic_evt_e evt,
  output logic [CNT_W-1:0]  cnt,
  output logic              flag
);
  import cic_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LVL     = CNT_W'(FLAG_LVL);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    unique case (evt)
      EV_CLEAR: cnt_nxt = '0;
      EV_COUNT: if (cnt != CNT_MAX) cnt_nxt = cnt + 1'b1;
      default:  cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      flag <= (cnt_nxt >= LVL);
    end
  end

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && evt != EV_CLEAR) |=> cnt == CNT_MAX);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (evt != EV_CLEAR) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  assert_flag_level_R7: assert property (@(posedge clk) disable iff (rst)
    flag == (cnt >= LVL));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (evt == EV_CLEAR) |=> (cnt == '0 && !flag));

  initial begin
    assert_level_fits_R7: assert (FLAG_LVL > 0 && FLAG_LVL < (1 << CNT_W))
      else $error("flag level does not fit the counter");
  end

endmodule

// File: rtl/cap_inacc_counter.sv
module cap_inacc_counter #(
  parameter int CAP_W    = cic_pkg::CIC_CAP_W,
  parameter int CNT_W    = cic_pkg::CIC_CNT_W,
  parameter int FLAG_LVL = cic_pkg::CIC_FLAG_LVL,
  parameter int PCT_NUM  = cic_pkg::CIC_PCT_NUM,
  parameter int PCT_DEN  = cic_pkg::CIC_PCT_DEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             charge_ok,
  input  logic             learn_upd,
  input  logic [CAP_W-1:0] avail_cap,
  input  logic [CAP_W-1:0] learned_cap,
  output logic [CNT_W-1:0] charge_cnt,
  output logic             inacc_flag
);
  import cic_pkg::*;

  logic     near_full;
  logic     inhibit;
  cic_evt_e evt;

  cic_threshold #(
    .CAP_W  (CAP_W),
    .PCT_NUM(PCT_NUM),
    .PCT_DEN(PCT_DEN)
  ) u_thr (
    .avail_cap  (avail_cap),
    .learned_cap(learned_cap),
    .near_full  (near_full)
  );

  cic_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .charge_ok(charge_ok),
    .learn_upd(learn_upd),
    .near_full(near_full),
    .evt      (evt),
    .inhibit  (inhibit)
  );

  cic_counter #(
    .CNT_W   (CNT_W),
    .FLAG_LVL(FLAG_LVL)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .evt (evt),
    .cnt (charge_cnt),
    .flag(inacc_flag)
  );

  // Blocked near-full charge leaves the count alone (R4)
  assert_blocked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (charge_ok && near_full && inhibit && !learn_upd) |=> $stable(charge_cnt));

  // Update beats a simultaneous charge (R9)
  assert_update_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (charge_ok && learn_upd) |=> charge_cnt == '0);

  // Quiet cycle holds state (R10)
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!charge_ok && !learn_upd) |=> ($stable(charge_cnt) && $stable(inacc_flag)));

  // Charge below threshold always counts unless saturated (R2)
  assert_below_counts_R2: assert property (@(posedge clk) disable iff (rst)
    (charge_ok && !near_full && !learn_upd && charge_cnt != '1)
      |=> charge_cnt == $past(charge_cnt) + 1'b1);

endmodule

// File: tb/cap_inacc_counter_test.sv
module cap_inacc_counter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        charge_ok = 1'b0;
  logic        learn_upd = 1'b0;
  logic [15:0] avail_cap = 16'd0;
  logic [15:0] learned_cap = 16'd0;
  logic [7:0]  charge_cnt;
  logic        inacc_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cap_inacc_counter uut (
    .clk        (clk),
    .rst        (rst),
    .charge_ok  (charge_ok),
    .learn_upd  (learn_upd),
    .avail_cap  (avail_cap),
    .learned_cap(learned_cap),
    .charge_cnt (charge_cnt),
    .inacc_flag (inacc_flag)
  );

  task automatic chk(input string req, input int exp_cnt, input bit exp_flag);
    checks++;
    if (charge_cnt !== 8'(exp_cnt) || inacc_flag !== exp_flag) begin
      errors++;
      $display("FAIL %s: cnt=%0d flag=%0b expected cnt=%0d flag=%0b",
               req, charge_cnt, inacc_flag, exp_cnt, exp_flag);
    end
  endtask

  // Drive for one cycle starting at a falling edge; result visible at the next falling edge
  task automatic step(input bit c, input bit l);
    charge_ok = c;
    learn_upd = l;
    @(negedge clk);
    charge_ok = 1'b0;
    learn_upd = 1'b0;
  endtask

  task automatic set_cap(input int a, input int m);
    avail_cap   = 16'(a);
    learned_cap = 16'(m);
  endtask

  task automatic t_reset;
    chk("R1 reset", 0, 1'b0);
  endtask

  task automatic t_below;
    set_cap(500, 1000);
    step(1, 0); chk("R2 first below", 1, 1'b0);
    step(1, 0); step(1, 0); chk("R2 three below", 3, 1'b0);
    step(0, 0); step(0, 0); chk("R10 idle hold", 3, 1'b0);
  endtask

  task automatic t_near;
    set_cap(1000, 1000);
    step(1, 0); chk("R3 first near-full", 4, 1'b0);
    step(1, 0); step(1, 0); chk("R4 repeat ignored", 4, 1'b0);
    set_cap(939, 1000);
    step(0, 0); chk("R4 dip no charge", 4, 1'b0);
    set_cap(1000, 1000);
    step(1, 0); chk("R4 re-armed after dip", 5, 1'b0);
    step(1, 0); chk("R4 blocked again", 5, 1'b0);
  endtask

  task automatic t_boundary;
    step(0, 1); chk("R8 clear before boundary", 0, 1'b0);
    set_cap(94, 100);
    step(1, 0); chk("R5 94/100 near-full counts once", 1, 1'b0);
    step(1, 0); chk("R5 94/100 treated as near-full", 1, 1'b0);
    set_cap(93, 100);
    step(1, 0); step(1, 0); chk("R5 93/100 below", 3, 1'b0);
    set_cap(61603, 65535);
    step(1, 0); chk("R5 wide near-full first", 4, 1'b0);
    step(1, 0); chk("R5 wide near-full blocked", 4, 1'b0);
    set_cap(61602, 65535);
    step(1, 0); step(1, 0); chk("R5 wide below", 6, 1'b0);
  endtask

  task automatic t_flag_sat;
    step(0, 1);
    set_cap(10, 1000);
    for (int i = 0; i < 63; i++) step(1, 0);
    chk("R7 at 63 flag low", 63, 1'b0);
    step(1, 0); chk("R7 at 64 flag high", 64, 1'b1);
    for (int i = 0; i < 191; i++) step(1, 0);
    chk("R6 reached 255", 255, 1'b1);
    step(1, 0); step(1, 0); step(1, 0);
    chk("R6 no wrap", 255, 1'b1);
  endtask

  task automatic t_learn;
    step(0, 1); chk("R8 update clears count and flag", 0, 1'b0);
    set_cap(1000, 1000);
    step(1, 0); chk("R8 near-full counts", 1, 1'b0);
    step(1, 0); chk("R8 near-full blocked", 1, 1'b0);
    step(0, 1); chk("R8 update clears", 0, 1'b0);
    step(1, 0); chk("R8 latch re-armed by update", 1, 1'b0);
  endtask

  task automatic t_collide;
    set_cap(10, 1000);
    step(1, 0); step(1, 0); chk("R9 setup", 3, 1'b0);
    step(1, 1); chk("R9 update wins", 0, 1'b0);
    step(0, 0); chk("R9 stays zero", 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_below();
    t_near();
    t_boundary();
    t_flag_sat();
    t_learn();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule